// File: doc/BRIEF.md
# Word Add/Subtract Unit with Condition Flags

This unit adds or subtracts two words and keeps four condition flags in a small status register. On a subtract it computes the destination word minus the source word. The result word is combinational: it follows the operands and the operation select with no clock delay. The flags are held in a register. They take the values from the current operation on the clock edge where an operation is marked valid.

A separate clear strobe zeroes all four flags on the next edge. It is used where an instruction stream wants a known flag state, and it wins over an operation issued in the same cycle. The data width is a parameter whose default is 16 bits. The flag layout is fixed, because neighbouring logic decodes the status bits by position.

Top module: `addsub_flags_unit`

## Requirements
- R1: With opSub low, resultWord equals (dstWord + srcWord) modulo 2^WIDTH, combinationally in the same cycle.
- R2: With opSub high, resultWord equals (dstWord - srcWord) modulo 2^WIDTH, combinationally in the same cycle.
- R3: flagsOut packs N at bit 3, Z at bit 2, V at bit 1 and C at bit 0. On the clock edge that samples opValid high with clrFlags low, the register loads N as the MSB of the result and Z high exactly when the result is all zeros.
- R4: On an add, the loaded C is the unsigned carry out of the most significant bit (for example 65535 + 1 gives 0 with flags 0101).
- R5: On a subtract, the loaded C is a borrow: it is set exactly when srcWord is greater than dstWord as an unsigned value (for example 1 - 65535 gives 2 with flags 0001).
- R6: On an add, the loaded V is set when both operands have the same sign bit and the result's sign bit differs from it (for example 1 + 32767 gives 32768 with flags 1010).
- R7: On a subtract, the loaded V is set when the operands' sign bits differ and the result's sign bit equals that of srcWord (for example 1 - 32768 gives 32769 with flags 1011).
- R8: clrFlags high on a clock edge sets flagsOut to 0000 after that edge, even when opValid is also high.
- R9: When opValid and clrFlags are both low on a clock edge, flagsOut keeps its value, whatever the operands and opSub do.
- R10: While rstN is low, flagsOut is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Loads the flags from the current operation on the next edge |
| opSub | input | 1 | 0 = add, 1 = subtract (destination minus source) |
| clrFlags | input | 1 | Zeroes all flags on the next edge; overrides opValid |
| dstWord | input | WIDTH | Destination operand (minuend on subtract) |
| srcWord | input | WIDTH | Source operand (subtrahend on subtract) |
| resultWord | output | WIDTH | Combinational sum or difference |
| flagsOut | output | 4 | Registered flags {N, Z, V, C} |

## Verification
The properties assume that the operands and opSub stay steady from the clock edge that samples opValid until that edge has passed. Under that assumption, the past result they compare against is the one the flags were loaded from. The bench drives every input on the falling edge and holds it across the following rising edge, so this always holds. The properties also assume that clrFlags is a plain level sampled on each edge. The bench raises clrFlags for a single cycle, alone and together with opValid, and never in a pattern that depends on the result.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_V = 1;
  localparam int FLAG_C = 0;
  localparam int FLAG_COUNT = 4;

  typedef struct packed {
    logic selSub;   // datapath inverts source and adds one
    logic capture;  // load flag register from the current operation
    logic wipe;     // force flag register to zero
  } ctl_strobes_t;

endpackage

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
  import addsub_pkg::*;
(
  input  logic         opValid,
  input  logic         opSub,
  input  logic         clrFlags,
  output ctl_strobes_t ctl
);

  always_comb begin
    ctl.selSub  = opSub;
    ctl.wipe    = clrFlags;
    ctl.capture = opValid & ~clrFlags;  // clear has priority (R8)
  end

endmodule

// File: rtl/addsub_datapath.sv
module addsub_datapath
  import addsub_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctl_strobes_t          ctl,
  input  logic [WIDTH-1:0]      dstWord,
  input  logic [WIDTH-1:0]      srcWord,
  output logic [WIDTH-1:0]      resultWord,
  output logic [FLAG_COUNT-1:0] flagsOut
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0]      operandB;
  logic [WIDTH:0]        sumExt;
  logic                  carryOut;
  logic [FLAG_COUNT-1:0] flagsNext;
  logic [FLAG_COUNT-1:0] flagsQ;

  always_comb begin
    operandB   = ctl.selSub ? ~srcWord : srcWord;
    sumExt     = {1'b0, dstWord} + {1'b0, operandB} + {{WIDTH{1'b0}}, ctl.selSub};
    resultWord = sumExt[MSB:0];
    carryOut   = sumExt[WIDTH];

    flagsNext         = '0;
    flagsNext[FLAG_N] = resultWord[MSB];
    flagsNext[FLAG_Z] = (resultWord == '0);
    flagsNext[FLAG_V] = (dstWord[MSB] == operandB[MSB]) && (resultWord[MSB] != dstWord[MSB]);
    flagsNext[FLAG_C] = ctl.selSub ? ~carryOut : carryOut;  // borrow on subtract
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            flagsQ <= '0;
    else if (ctl.wipe)    flagsQ <= '0;
    else if (ctl.capture) flagsQ <= flagsNext;
  end

  assign flagsOut = flagsQ;

endmodule

// File: rtl/addsub_flags_unit.sv
module addsub_flags_unit
  import addsub_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic             opSub,
  input  logic             clrFlags,
  input  logic [WIDTH-1:0] dstWord,
  input  logic [WIDTH-1:0] srcWord,
  output logic [WIDTH-1:0] resultWord,
  output logic [3:0]       flagsOut
);

  ctl_strobes_t ctl;

  addsub_ctrl i_ctrl (
    .opValid  (opValid),
    .opSub    (opSub),
    .clrFlags (clrFlags),
    .ctl      (ctl)
  );

  addsub_datapath #(.WIDTH(WIDTH)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .dstWord    (dstWord),
    .srcWord    (srcWord),
    .resultWord (resultWord),
    .flagsOut   (flagsOut)
  );

endmodule

// File: rtl/addsub_flags_checker.sv
module addsub_flags_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             opValid,
  input logic             opSub,
  input logic             clrFlags,
  input logic [WIDTH-1:0] dstWord,
  input logic [WIDTH-1:0] srcWord,
  input logic [WIDTH-1:0] resultWord,
  input logic [3:0]       flagsOut
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] backAdd;
  logic [WIDTH-1:0] backSub;
  assign backAdd = resultWord - srcWord;
  assign backSub = resultWord + srcWord;

  assert_sum_R1: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !opSub) |-> (backAdd == dstWord));

  assert_diff_R2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSub) |-> (backSub == dstWord));

  assert_nz_R3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !clrFlags) |=>
      (flagsOut[3] == $past(resultWord[MSB])) && (flagsOut[2] == ($past(resultWord) == '0)));

  assert_carry_R4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !opSub && !clrFlags) |=> (flagsOut[0] == ($past(resultWord) < $past(dstWord))));

  assert_borrow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSub && !clrFlags) |=> (flagsOut[0] == ($past(srcWord) > $past(dstWord))));

  assert_add_ovf_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !opSub && !clrFlags) |=>
      (flagsOut[1] == (($past(dstWord[MSB]) == $past(srcWord[MSB])) &&
                       ($past(resultWord[MSB]) != $past(dstWord[MSB])))));

  assert_sub_ovf_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSub && !clrFlags) |=>
      (flagsOut[1] == (($past(dstWord[MSB]) != $past(srcWord[MSB])) &&
                       ($past(resultWord[MSB]) == $past(srcWord[MSB])))));

  assert_wipe_R8: assert property (@(posedge clk) disable iff (!rstN)
    clrFlags |=> (flagsOut == 4'b0000));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid && !clrFlags) |=> $stable(flagsOut));

  assert_reset_R10: assert property (@(posedge clk)
    !rstN |-> (flagsOut == 4'b0000));

endmodule

bind addsub_flags_unit addsub_flags_checker #(.WIDTH(WIDTH)) i_checker (
  .clk        (clk),
  .rstN       (rstN),
  .opValid    (opValid),
  .opSub      (opSub),
  .clrFlags   (clrFlags),
  .dstWord    (dstWord),
  .srcWord    (srcWord),
  .resultWord (resultWord),
  .flagsOut   (flagsOut)
);

// File: tb/test_addsub_flags_unit.sv
module test_addsub_flags_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WIDE = 16;
  localparam int NARROW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic opSub = 1'b0;
  logic clrFlags = 1'b0;
  logic [WIDE-1:0]   dstW = '0, srcW = '0, resW;
  logic [NARROW-1:0] dstN = '0, srcN = '0, resN;
  logic [3:0] flagsW, flagsN;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addsub_flags_unit #(.WIDTH(WIDE)) i_addsub_flags_unit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSub(opSub), .clrFlags(clrFlags),
    .dstWord(dstW), .srcWord(srcW), .resultWord(resW), .flagsOut(flagsW));

  addsub_flags_unit #(.WIDTH(NARROW)) i_addsub_flags_unit_narrow (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSub(opSub), .clrFlags(clrFlags),
    .dstWord(dstN), .srcWord(srcN), .resultWord(resN), .flagsOut(flagsN));

  // Expected {flags, result} from plain integer arithmetic.
  function automatic logic [19:0] model(int w, bit sub, int d, int s);
    int modv = 1 << w;
    int half = modv / 2;
    int raw = sub ? d - s : d + s;
    int res = ((raw % modv) + modv) % modv;
    int sd = (d >= half) ? d - modv : d;
    int ss = (s >= half) ? s - modv : s;
    int sr = sub ? sd - ss : sd + ss;
    logic [3:0] f;
    f[3] = (res >= half);
    f[2] = (res == 0);
    f[1] = (sr >= half) || (sr < -half);
    f[0] = sub ? (s > d) : (raw >= modv);
    return {f, res[15:0]};
  endfunction

  task automatic check(string tag, int actual, int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  function automatic string flagTag(bit sub, logic [3:0] act, logic [3:0] exp);
    if (act[3:2] != exp[3:2]) return "R3";
    if (act[0] != exp[0]) return sub ? "R5" : "R4";
    return sub ? "R7" : "R6";
  endfunction

  // One operation on one instance: drive at falling edge, check at the next
  // falling edge (result is combinational, flags were loaded at the rising edge).
  task automatic runOp(bit narrow, bit sub, int d, int s);
    logic [19:0] e;
    int w = narrow ? NARROW : WIDE;
    e = model(w, sub, d, s);
    opValid = 1'b1; opSub = sub;
    if (narrow) begin dstN = d[NARROW-1:0]; srcN = s[NARROW-1:0]; end
    else        begin dstW = d[WIDE-1:0];   srcW = s[WIDE-1:0];   end
    @(negedge clk);
    if (narrow) begin
      check(sub ? "R2" : "R1", int'(resN), int'(e[NARROW-1:0]));
      check(flagTag(sub, flagsN, e[19:16]), int'(flagsN), int'(e[19:16]));
    end else begin
      check(sub ? "R2" : "R1", int'(resW), int'(e[15:0]));
      check(flagTag(sub, flagsW, e[19:16]), int'(flagsW), int'(e[19:16]));
    end
    opValid = 1'b0;
  endtask

  initial begin
    int corners[6] = '{0, 1, 32767, 32768, 65535, 21845};
    logic [3:0] held;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", int'(flagsW), 0);
    check("R10", int'(flagsN), 0);
    rstN = 1'b1;
    @(negedge clk);

    // Worked cases for R3 R4 R5 R6 R7
    runOp(1'b0, 1'b0, 1, 32767);     // 32768, 1010
    check("R6", int'(flagsW), 4'b1010);
    runOp(1'b0, 1'b0, 65535, 1);     // 0, 0101
    check("R4", int'(flagsW), 4'b0101);
    runOp(1'b0, 1'b0, 0, 0);         // 0, 0100
    check("R3", int'(flagsW), 4'b0100);
    runOp(1'b0, 1'b1, 1, 32768);     // 32769, 1011
    check("R7", int'(flagsW), 4'b1011);
    runOp(1'b0, 1'b1, 1, 65535);     // 2, 0001
    check("R5", int'(flagsW), 4'b0001);
    check("R2", int'(resW), 2);

    // Wide corner-value sweep, both operations
    for (int op = 0; op < 2; op++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          runOp(1'b0, op[0], corners[i], corners[j]);

    // Exhaustive narrow sweep, both operations
    for (int op = 0; op < 2; op++)
      for (int d = 0; d < (1 << NARROW); d++)
        for (int s = 0; s < (1 << NARROW); s++)
          runOp(1'b1, op[0], d, s);

    // R9: idle cycles with changing operands leave flags alone
    runOp(1'b0, 1'b1, 1, 32768);     // flags 1011
    held = flagsW;
    opSub = 1'b0; dstW = 16'h0000; srcW = 16'h0000;
    @(negedge clk);
    check("R9", int'(flagsW), int'(held));
    dstW = 16'hffff; srcW = 16'h0001; opSub = 1'b1;
    @(negedge clk);
    check("R9", int'(flagsW), int'(held));

    // R8: clear alone, then clear together with a valid operation
    clrFlags = 1'b1;
    @(negedge clk);
    clrFlags = 1'b0;
    check("R8", int'(flagsW), 0);
    runOp(1'b0, 1'b0, 65535, 1);     // flags 0101
    clrFlags = 1'b1; opValid = 1'b1; opSub = 1'b0; dstW = 16'h7fff; srcW = 16'h0001;
    @(negedge clk);
    clrFlags = 1'b0; opValid = 1'b0;
    check("R8", int'(flagsW), 0);
    check("R8", int'(flagsN), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule